// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Half-Line Rejection

This block turns a sampled, active-low composite sync into a clean, active-low horizontal sync train with one pulse per line. Each output pulse starts on a leading (falling) edge of the composite sync and lasts a fixed number of clock cycles, whatever the width of the input pulse. During vertical blanking the composite sync carries equalizing and serration pulses at twice the line rate. The block removes them with a hold-off window. The window opens at every accepted leading edge and ignores any further leading edge until it closes.

The input passes through a synchronizer chain before edge detection. A three-state machine emits the pulses. The states are ARMED (output high, waiting for a leading edge), PULSE (output low, counting the width) and HOLD (output high, counting out the remaining hold-off). There are three transitions. ARMED goes to PULSE on a leading edge. PULSE goes to HOLD when the width count ends. HOLD goes to ARMED when the hold-off count ends. Width and hold-off are parameters in clock cycles. The hold-off is set to about three quarters of a line, and both values scale inversely with the scan rate. The block never makes a pulse without an input edge.

Top module: `hsync_regen`

## Requirements
- R1: While reset is asserted, and afterwards until a leading edge is accepted, `hsync_n` is high. Reset clears the width and hold-off counters, so a leading edge that arrives right after reset is accepted.
- R2: A leading edge means a 1-to-0 transition of `csync_n`. With the default two-stage synchronizer, `hsync_n` goes low at the third rising clock edge after the input falls.
- R3: Every output pulse is low for exactly `PULSE_W` clock cycles. This holds for input pulses both shorter and longer than `PULSE_W`.
- R4: A leading edge that comes d cycles after an accepted leading edge is ignored when d ≤ `HOLDOFF`. A half-line-spaced edge is one such case.
- R5: A leading edge with d ≥ `HOLDOFF`+1 is accepted and starts a new pulse.
- R6: Rising edges of `csync_n` never start a pulse. Holding `csync_n` steadily high or low after the hold-off ends produces no further pulses.
- R7: A sync train whose line-spaced edges are interrupted by a run of half-line-spaced edges produces exactly one output pulse per line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Composite sync, active low, asynchronous to clk |
| hsync_n | output | 1 | Regenerated horizontal sync, active low |

## Verification
The hardest case to reach from the ports is a leading edge that lands exactly on the boundary of the hold-off window. There, one cycle decides whether the edge is ignored or accepted. The stimulus sends pairs of short input pulses whose leading edges are `HOLDOFF` and `HOLDOFF`+1 cycles apart, and counts the output pulses for each pair. A second hard case is reset arriving in the middle of a pulse. The bench asserts reset while the output is low, then drives a new edge straight away, which shows that the stale hold-off was cleared.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    typedef enum logic [1:0] {
        HS_ARMED = 2'd0,
        HS_PULSE = 2'd1,
        HS_HOLD  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hsr_sync_edge.sv
// Synchronizer chain plus leading-edge (1->0) detector.
module hsr_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lead_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              level;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level;
    end

    assign lead_o = prev_q & ~level;

    // R6: a leading edge is only reported when the synchronized level was high before
    AST_LEAD_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |-> $past(level)) else $error("lead without prior high"); // R6
endmodule

// File: rtl/hsr_fsm.sv
// Pulse generator and hold-off timer.
module hsr_fsm
    import hsr_pkg::*;
#(
    parameter int unsigned PULSE_W = 135,
    parameter int unsigned HOLDOFF = 1287
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_i,
    output logic hsync_n_o
);
    localparam int unsigned CNT_W  = $clog2(HOLDOFF + 1);
    localparam int unsigned GAP_W  = $clog2(HOLDOFF + 2);
    localparam int unsigned LOW_W  = $clog2(PULSE_W + 1);
    localparam logic [CNT_W-1:0] LAST_W = CNT_W'(PULSE_W - 1);
    localparam logic [CNT_W-1:0] LAST_H = CNT_W'(HOLDOFF - 1);

    hs_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = (state_q == HS_ARMED) ? '0 : cnt_q + 1'b1;
        unique case (state_q)
            HS_ARMED: if (lead_i)          state_d = HS_PULSE;
            HS_PULSE: if (cnt_q == LAST_W) state_d = HS_HOLD;
            HS_HOLD:  if (cnt_q == LAST_H) state_d = HS_ARMED;
            default:                       state_d = HS_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        hsync_n_o = (state_q != HS_PULSE);
    end

    // Checker state: length of the current low run and gap between output starts
    logic [LOW_W-1:0] low_run_q;
    logic [GAP_W-1:0] gap_q;
    logic             hs_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
            gap_q     <= GAP_W'(HOLDOFF + 1);
            hs_prev_q <= 1'b1;
        end else begin
            hs_prev_q <= hsync_n_o;
            if (!hsync_n_o && low_run_q < LOW_W'(PULSE_W)) low_run_q <= low_run_q + 1'b1;
            else if (hsync_n_o)                               low_run_q <= '0;
            if (hs_prev_q && !hsync_n_o)                      gap_q <= GAP_W'(1);
            else if (gap_q < GAP_W'(HOLDOFF + 1))             gap_q <= gap_q + 1'b1;
        end
    end

    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n_o) |-> $past(lead_i)) else $error("pulse without edge"); // R2
    AST_WIDTH_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n_o) |-> low_run_q == LOW_W'(PULSE_W)) else $error("bad width"); // R3
    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n_o |-> low_run_q < LOW_W'(PULSE_W)) else $error("pulse too long"); // R3
    AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_prev_q && !hsync_n_o) |-> gap_q > GAP_W'(HOLDOFF)) else $error("hold-off violated"); // R4
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PULSE_W     = 135,
    parameter int unsigned HOLDOFF     = 1287
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic hsync_n
);
    logic lead;

    hsr_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (csync_n),
        .lead_o (lead)
    );

    hsr_fsm #(.PULSE_W(PULSE_W), .HOLDOFF(HOLDOFF)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead_i    (lead),
        .hsync_n_o (hsync_n)
    );

    AST_RESET_HIGH: assert property (@(posedge clk) !rst_n |-> hsync_n)
        else $error("output low in reset"); // R1
endmodule

// File: tb/test_hsync_regen.sv
module test_hsync_regen;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 6;
    localparam int HO = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b1;
    logic hsync_n;

    int tests = 0;
    int fails = 0;
    int falls = 0;
    logic hs_prev = 1'b1;

    hsync_regen #(.SYNC_STAGES(2), .PULSE_W(PW), .HOLDOFF(HO)) i_hsync_regen (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .hsync_n(hsync_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && hs_prev && !hsync_n) falls++;
        hs_prev = hsync_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R2, R3: one leading edge, input low for in_low cycles
    task automatic run_pulse(input int in_low, input string tag);
        int first = -1;
        int lows = 0;
        csync_n = 1'b0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (i == in_low) csync_n = 1'b1;
            if (!hsync_n) begin
                lows++;
                if (first < 0) first = i;
            end
        end
        csync_n = 1'b1;
        chk(first == 3, {"R2 latency ", tag}, first, 3);
        chk(lows == PW, {"R3 width ", tag}, lows, PW);
    endtask

    // R4, R5: two leading edges d cycles apart
    task automatic two_edges(input int d, input int exp, input string req);
        int start = falls;
        for (int i = 0; i <= d + 60; i++) begin
            if (i == 0 || i == d) csync_n = 1'b0;
            if (i == 2 || i == d + 2) csync_n = 1'b1;
            @(negedge clk);
        end
        chk(falls - start == exp, req, falls - start, exp);
    endtask

    task automatic reset_checks();
        chk(hsync_n == 1'b1, "R1 high in reset", int'(hsync_n), 1);
        rst_n = 1'b1;
        idle(5);
        chk(hsync_n == 1'b1, "R1 high after reset", int'(hsync_n), 1);
    endtask

    task automatic steady_levels();
        int start = falls;
        csync_n = 1'b0;
        idle(200);
        chk(falls - start == 1, "R6 held low", falls - start, 1);
        start = falls;
        csync_n = 1'b1;
        idle(200);
        chk(falls - start == 0, "R6 rising edge and held high", falls - start, 0);
        chk(hsync_n == 1'b1, "R6 no inserted pulse", int'(hsync_n), 1);
    endtask

    // R7: edges every 16 cycles (half line) between line-spaced edges every 32
    task automatic blanking_train();
        int start = falls;
        for (int t = 0; t <= 400; t++) begin
            int e = t;
            int r = t - 2;
            if (e % 16 == 0 && e <= 352 && (e % 32 == 0 || (e >= 96 && e <= 272)))
                csync_n = 1'b0;
            if (r >= 0 && r % 16 == 0 && r <= 352 && (r % 32 == 0 || (r >= 96 && r <= 272)))
                csync_n = 1'b1;
            @(negedge clk);
        end
        chk(falls - start == 12, "R7 one pulse per line", falls - start, 12);
    endtask

    task automatic reset_mid_pulse();
        csync_n = 1'b0;
        idle(4);
        chk(hsync_n == 1'b0, "R1 pulse started", int'(hsync_n), 0);
        rst_n = 1'b0;
        csync_n = 1'b1;
        @(negedge clk);
        chk(hsync_n == 1'b1, "R1 reset forces high", int'(hsync_n), 1);
        idle(2);
        rst_n = 1'b1;
        idle(1);
        run_pulse(2, "R1 after reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        reset_checks();
        run_pulse(2, "short input");
        idle(HO);
        run_pulse(20, "long input");
        idle(HO);
        two_edges(HO, 1, "R4 edge at hold-off boundary ignored");
        two_edges(16, 1, "R4 half-line edge ignored");
        two_edges(HO + 1, 2, "R5 edge just after hold-off accepted");
        steady_levels();
        blanking_train();
        idle(HO + 10);
        reset_mid_pulse();
        idle(10);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule